// File: doc/BRIEF.md
# AV Byte-Stream Quadlet Packer

The block takes a byte-wide audio/video stream, sampled on the rising edge of the application clock, and packs it into 32-bit quadlets grouped into source packets, ready for an isochronous transmit path. A byte enters only on a cycle where the valid strobe is high. A start marker seen with valid opens a packet. A packet closes in one of two ways. If an end marker arrives with a byte, the packet closes on that byte and any partial quadlet is padded with zeros. Otherwise the packet closes once a configured number of quadlets has been produced.

Each quadlet leaves through a valid/ready output stage. It carries first and last flags and the running byte count of its packet. On the last quadlet that count is the packet's true length. Two sticky flags report faults: one for a start marker that arrives inside a packet, and one for bytes that were offered while the consumer was stalling.

Top module: `avQuadPacker`

## Requirements
- R1: Within a quadlet the first byte lands in bits [31:24], the second in [23:16], the third in [15:8] and the fourth in [7:0]; bit 7 of the input byte is its most significant bit.
- R2: A cycle with inValid low changes nothing: its inData, inSop and inEop are ignored.
- R3: A byte with inValid and inSop high opens a packet and is its first byte; bytes with inValid high outside any packet and without inSop are discarded.
- R4: A byte with inEop high closes the packet; a partial quadlet is emitted at once as the last quadlet with its unused lower lanes set to zero; inEop on a quadlet's fourth byte simply marks it last.
- R5: Without inEop a packet ends after PKT_QUADS quadlets, and that quadlet is flagged last.
- R6: outFirst is high only on a packet's first quadlet and outLast only on its last.
- R7: outByteCount gives the packet's bytes up to and including the current quadlet, so on the last quadlet it equals the packet length.
- R8: inSop with inValid inside an open packet sets the sticky frameErr, drops the partial quadlet and starts a new packet with that byte in lane [31:24]; quadlets already emitted stay emitted.
- R9: Once outValid is high it stays high with outData, outFirst, outLast and outByteCount unchanged until a cycle with outReady high.
- R10: While outReady is low no byte is accepted; a byte offered with inValid high in such a cycle is lost and sets the sticky overflow flag.
- R11: After reset outValid, frameErr and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Application clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Stream byte, bit 7 most significant |
| inValid | input | 1 | Byte strobe |
| inSop | input | 1 | Start of packet, qualified by inValid |
| inEop | input | 1 | End of packet, qualified by inValid |
| outReady | input | 1 | Consumer can take a quadlet |
| outValid | output | 1 | Quadlet present |
| outData | output | 32 | Packed quadlet |
| outFirst | output | 1 | First quadlet of a packet |
| outLast | output | 1 | Last quadlet of a packet |
| outByteCount | output | $clog2(PKT_QUADS*4+1) | Bytes of the packet so far |
| frameErr | output | 1 | Sticky: start marker inside a packet |
| overflow | output | 1 | Sticky: byte offered while stalled |

## Verification
Every packet length from one byte up to the full fixed length is sent closed by an end marker. This separates the four padding cases and shows an end marker on a fourth byte behaving the same as a plain full quadlet. The same lengths are repeated with idle cycles between bytes, and those idle cycles carry a start marker and junk data, which shows that invalid cycles are ignored. Full-length packets without an end marker, with stray unmarked bytes between packets, separate automatic closing from the discarding of bytes outside a packet. Dedicated sequences cover a restart in mid-packet, a stalled output that must hold its quadlet, and bytes lost to a stall.

// File: rtl/avqp_pkg.sv
package avqp_pkg;
  // Per-byte command from control to datapath
  typedef struct packed {
    logic       take;   // byte accepted this cycle
    logic       emit;   // quadlet complete, load output stage
    logic [1:0] lane;   // lane the accepted byte fills (0 = [31:24])
    logic       first;  // emitted quadlet opens its packet
    logic       last;   // emitted quadlet closes its packet
  } avqpStrobes_t;
endpackage

// File: rtl/avqpCtrl.sv
module avqpCtrl
  import avqp_pkg::*;
#(
  parameter int PKT_QUADS = 16,
  parameter int CNT_W     = $clog2(PKT_QUADS*4+1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSop,
  input  logic             inEop,
  input  logic             outReady,
  output avqpStrobes_t     strb,
  output logic [CNT_W-1:0] byteCount,
  output logic             frameErr,
  output logic             overflow
);
  localparam int QI_W = (PKT_QUADS > 1) ? $clog2(PKT_QUADS) : 1;
  localparam logic [QI_W-1:0] LAST_Q = QI_W'(PKT_QUADS-1);

  logic [1:0]       laneCnt;
  logic [QI_W-1:0]  quadIdx;
  logic [CNT_W-1:0] byteCnt;
  logic             inPacket;

  logic             take, restart, emit, last;
  logic [1:0]       effLane;
  logic [QI_W-1:0]  effQuad;
  logic [CNT_W-1:0] effCount;

  always_comb begin
    take     = inValid && outReady && (inSop || inPacket);
    restart  = take && inSop;
    effLane  = restart ? 2'd0 : laneCnt;
    effQuad  = restart ? '0 : quadIdx;
    effCount = restart ? CNT_W'(1) : byteCnt + CNT_W'(1);
    emit     = take && (effLane == 2'd3 || inEop);
    last     = emit && (inEop || effQuad == LAST_Q);
    strb.take  = take;
    strb.emit  = emit;
    strb.lane  = effLane;
    strb.first = (effQuad == '0);
    strb.last  = last;
    byteCount  = effCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneCnt  <= 2'd0;
      quadIdx  <= '0;
      byteCnt  <= '0;
      inPacket <= 1'b0;
      frameErr <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (take && inSop && inPacket) frameErr <= 1'b1;
      if (inValid && !outReady)      overflow <= 1'b1;
      if (take) begin
        if (last) begin
          laneCnt  <= 2'd0;
          quadIdx  <= '0;
          byteCnt  <= '0;
          inPacket <= 1'b0;
        end else if (emit) begin
          laneCnt  <= 2'd0;
          quadIdx  <= effQuad + QI_W'(1);
          byteCnt  <= effCount;
          inPacket <= 1'b1;
        end else begin
          laneCnt  <= effLane + 2'd1;
          quadIdx  <= effQuad;
          byteCnt  <= effCount;
          inPacket <= 1'b1;
        end
      end
    end
  end

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  // R10
  overflow_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !outReady) |=> overflow);
  // R8
  frame_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> frameErr);
  // R2
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(laneCnt) && $stable(quadIdx) && $stable(inPacket)));
endmodule

// File: rtl/avqpData.sv
module avqpData
  import avqp_pkg::*;
#(
  parameter int PKT_QUADS = 16,
  parameter int CNT_W     = $clog2(PKT_QUADS*4+1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  avqpStrobes_t     strb,
  input  logic [7:0]       inData,
  input  logic [CNT_W-1:0] countIn,
  input  logic             outReady,
  output logic             outValid,
  output logic [31:0]      outData,
  output logic             outFirst,
  output logic             outLast,
  output logic [CNT_W-1:0] outByteCount
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PKT_QUADS*4);

  logic [31:0] acc;
  logic [31:0] word;

  // lane 0 starts a fresh quadlet, which zeroes every padding lane
  always_comb begin
    word = (strb.lane == 2'd0) ? 32'd0 : acc;
    for (int l = 0; l < 4; l++) begin
      if (strb.lane == 2'(l)) word[31-8*l -: 8] = inData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc          <= '0;
      outValid     <= 1'b0;
      outData      <= '0;
      outFirst     <= 1'b0;
      outLast      <= 1'b0;
      outByteCount <= '0;
    end else begin
      if (strb.take) acc <= word;
      if (strb.emit) begin
        outValid     <= 1'b1;
        outData      <= word;
        outFirst     <= strb.first;
        outLast      <= strb.last;
        outByteCount <= countIn;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

  function automatic logic [31:0] padMask(input logic [1:0] used);
    case (used)
      2'd1:    padMask = 32'h00FF_FFFF;
      2'd2:    padMask = 32'h0000_FFFF;
      2'd3:    padMask = 32'h0000_00FF;
      default: padMask = 32'h0;
    endcase
  endfunction

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)
                                 && $stable(outFirst) && $stable(outByteCount)));
  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |-> ((outData & padMask(outByteCount[1:0])) == 32'd0));
  // R5
  full_is_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outByteCount == FULL_CNT) |-> outLast);
  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outByteCount != '0 && outByteCount <= FULL_CNT));
endmodule

// File: rtl/avQuadPacker.sv
module avQuadPacker
  import avqp_pkg::*;
#(
  parameter int PKT_QUADS = 16,
  localparam int CNT_W    = $clog2(PKT_QUADS*4+1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inSop,
  input  logic             inEop,
  input  logic             outReady,
  output logic             outValid,
  output logic [31:0]      outData,
  output logic             outFirst,
  output logic             outLast,
  output logic [CNT_W-1:0] outByteCount,
  output logic             frameErr,
  output logic             overflow
);
  avqpStrobes_t     strb;
  logic [CNT_W-1:0] byteCount;

  avqpCtrl #(.PKT_QUADS(PKT_QUADS), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .outReady(outReady), .strb(strb), .byteCount(byteCount),
    .frameErr(frameErr), .overflow(overflow)
  );

  avqpData #(.PKT_QUADS(PKT_QUADS), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .countIn(byteCount),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .outFirst(outFirst), .outLast(outLast), .outByteCount(outByteCount)
  );

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && !frameErr && !overflow));
endmodule

// File: tb/sim_avQuadPacker.sv
module sim_avQuadPacker;
  localparam int PQ    = 3;
  localparam int CNT_W = $clog2(PQ*4+1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inSop = 1'b0, inEop = 1'b0, outReady = 1'b1;
  logic outValid, outFirst, outLast, frameErr, overflow;
  logic [31:0] outData;
  logic [CNT_W-1:0] outByteCount;

  always #10 clk = ~clk;

  avQuadPacker #(.PKT_QUADS(PQ)) u0 (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inSop(inSop),
    .inEop(inEop), .outReady(outReady), .outValid(outValid), .outData(outData),
    .outFirst(outFirst), .outLast(outLast), .outByteCount(outByteCount),
    .frameErr(frameErr), .overflow(overflow)
  );

  int checks = 0, fails = 0;
  int expIdx = 0, gotIdx = 0;
  bit done = 0, monOn = 0;
  logic [31:0] expData [0:1023];
  logic        expFirst[0:1023];
  logic        expLast [0:1023];
  int          expCnt  [0:1023];
  logic [7:0]  pb [0:63];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected quadlets of a packet held in pb[0..len-1]
  task automatic pushPacket(input int len);
    int nq = (len + 3) / 4;
    for (int q = 0; q < nq; q++) begin
      logic [31:0] w = '0;
      for (int l = 0; l < 4; l++)
        if (4*q + l < len) w[31-8*l -: 8] = pb[4*q + l];
      expData[expIdx]  = w;
      expFirst[expIdx] = (q == 0);
      expLast[expIdx]  = (q == nq - 1);
      expCnt[expIdx]   = (4*q + 4 < len) ? 4*q + 4 : len;
      expIdx++;
    end
  endtask

  always @(negedge clk) begin
    if (monOn && outValid && outReady) begin
      check(outData == expData[gotIdx], "R1/R4", "quadlet data", outData, expData[gotIdx]);
      check(outFirst == expFirst[gotIdx], "R6", "first flag", outFirst, expFirst[gotIdx]);
      check(outLast == expLast[gotIdx], "R5/R6", "last flag", outLast, expLast[gotIdx]);
      check(int'(outByteCount) == expCnt[gotIdx], "R7", "byte count", outByteCount, expCnt[gotIdx]);
      gotIdx++;
    end
  end

  task automatic drive(input logic [7:0] d, input bit v, input bit s, input bit e);
    @(posedge clk); #2;
    inData = d; inValid = v; inSop = s; inEop = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(8'h5A, 0, 0, 0);
  endtask

  task automatic doReset();
    @(posedge clk); #2;
    rstN = 0; inValid = 0; inSop = 0; inEop = 0; outReady = 1;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
  endtask

  // send pb[0..len-1]; gap>0 inserts an invalid cycle carrying sop and junk
  task automatic sendPacket(input int len, input bit useEop, input int gap);
    for (int i = 0; i < len; i++) begin
      drive(pb[i], 1, i == 0, useEop && (i == len - 1));
      if (gap > 0 && (i % gap) == gap - 1) drive(8'hC3, 0, 1, 1);
    end
    drive(8'h00, 0, 0, 0);
  endtask

  task automatic fillBytes(input int seed, input int len);
    for (int i = 0; i < len; i++) pb[i] = 8'(seed * 37 + i * 11 + 5);
  endtask

  task automatic drainCheck(input string tag);
    idle(4);
    check(gotIdx == expIdx, tag, "quadlets received", gotIdx, expIdx);
  endtask

  initial begin
    doReset();
    @(negedge clk);
    // R11
    check(outValid == 0, "R11", "outValid after reset", outValid, 0);
    check(frameErr == 0, "R11", "frameErr after reset", frameErr, 0);
    check(overflow == 0, "R11", "overflow after reset", overflow, 0);
    monOn = 1;

    // R1 R4 R2: every length closed by end marker, three gap patterns
    for (int g = 0; g < 3; g++) begin
      for (int len = 1; len <= PQ*4; len++) begin
        fillBytes(len + 16*g, len);
        pushPacket(len);
        sendPacket(len, 1, g == 0 ? 0 : g + 1);
        // R3: stray unmarked bytes between packets are discarded
        drive(8'hEE, 1, 0, 0);
        drive(8'hDD, 1, 0, 0);
      end
    end
    // R5: fixed-length packets with no end marker
    for (int k = 0; k < 3; k++) begin
      fillBytes(90 + k, PQ*4);
      pushPacket(PQ*4);
      sendPacket(PQ*4, 0, k);
      drive(8'h77, 1, 0, 0);
    end
    drainCheck("R3/R5");
    check(frameErr == 0, "R2", "frameErr with invalid-cycle sop", frameErr, 0);
    check(overflow == 0, "R10", "overflow with ready held", overflow, 0);

    // R8: restart in mid-packet
    doReset();
    fillBytes(200, 6);
    pushPacket(4);
    expLast[expIdx-1] = 0;
    expCnt[expIdx-1]  = 4;
    for (int i = 0; i < 6; i++) drive(pb[i], 1, i == 0, 0);
    fillBytes(201, 5);
    pushPacket(5);
    sendPacket(5, 1, 0);
    drainCheck("R8");
    check(frameErr == 1, "R8", "frameErr after mid-packet sop", frameErr, 1);

    // R9: stalled output holds its quadlet
    doReset();
    fillBytes(210, 4);
    pushPacket(4);
    for (int i = 0; i < 4; i++) drive(pb[i], 1, i == 0, i == 3);
    @(posedge clk); #2;
    inValid = 0; inEop = 0; inSop = 0; outReady = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(outValid == 1, "R9", "outValid during stall", outValid, 1);
      check(outData == expData[expIdx-1], "R9", "data during stall", outData, expData[expIdx-1]);
    end
    @(posedge clk); #2 outReady = 1;
    drainCheck("R9");
    check(overflow == 0, "R10", "overflow with idle stall", overflow, 0);

    // R10: bytes offered while stalled are lost
    pb[0] = 8'h11; pb[1] = 8'h44; pb[2] = 8'h55; pb[3] = 8'h66;
    pushPacket(4);
    drive(8'h11, 1, 1, 0);
    @(posedge clk); #2;
    outReady = 0; inData = 8'h22; inValid = 1; inSop = 0;
    @(posedge clk); #2 inData = 8'h33;
    @(posedge clk); #2 outReady = 1; inValid = 0;
    drive(8'h44, 1, 0, 0);
    drive(8'h55, 1, 0, 0);
    drive(8'h66, 1, 0, 1);
    drive(8'h00, 0, 0, 0);
    drainCheck("R10");
    check(overflow == 1, "R10", "overflow after stalled bytes", overflow, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule